// File: doc/BRIEF.md
# Shared bus arbiter with atomic hold

This block decides which of several agents drives a single shared memory bus. Each agent raises a request line and receives a one-hot grant. Once an agent owns the bus it can hold it through a multi-access atomic sequence, such as a read-modify-write, by raising its lock line. No other agent is granted until that hold ends, so locked sequences are never interleaved with another agent's accesses.

A second per-agent hold input, the implicit lock, covers operations that are always atomic whether or not software asked for it. These include a memory exchange, an interrupt-acknowledge cycle that carries a vector on the data bus, and a test-and-set of a task busy flag. Both hold inputs count only for the agent that currently has the grant. A transfer-busy input from the bus also stops the grant from moving while an access is in flight. When the bus is free and not held, the next owner is picked round-robin, starting with the agent after the last one granted.

Top module: `shared_bus_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every grant bit is 0 and locked_o is 0. The round-robin search then starts at agent 0, so if all agents request, agent 0 gets the first grant.
- R2: gnt_o has at most one bit set in every cycle. Bit k set means agent k owns the bus.
- R3: An agent that newly receives the grant had its req_i bit high at the clock edge where the grant changed.
- R4: At a clock edge where the bus is neither busy nor held, the new owner is the first requesting agent, searching upward with wrap-around from the agent after the last agent granted.
- R5: While xfer_busy_i is high at a clock edge, gnt_o keeps its value through that edge.
- R6: While the current owner holds lock_i high at a clock edge, gnt_o keeps its value through that edge, whatever the other agents request.
- R7: auto_lock_i, used for exchanges, interrupt-acknowledge vector transfers and busy-flag test-and-set, holds the grant exactly as lock_i does.
- R8: lock_i or auto_lock_i from an agent without the grant is ignored. It neither holds the bus nor raises locked_o, and with no grant locked_o is 0.
- R9: locked_o is high in the same cycle that the current owner has lock_i or auto_lock_i high.
- R10: At a clock edge where the bus is neither busy nor held and no agent requests, the grant clears to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N | Per-agent bus request |
| lock_i | input | N | Per-agent explicit atomic hold |
| auto_lock_i | input | N | Per-agent implicit atomic hold (exchange, interrupt acknowledge, busy-flag test-and-set) |
| xfer_busy_i | input | 1 | A bus access is in progress; the grant must not move |
| gnt_o | output | N | One-hot grant, or zero when the bus is unowned |
| locked_o | output | 1 | The bus is held by its owner for an atomic sequence |

## Verification
The bench targets a lock raised by an agent that does not own the bus. A design that qualified lock with the request instead of the grant would freeze on the wrong owner or report a held bus with no owner. It checks that the implicit hold freezes the grant exactly like the explicit one, so a design that ignored it would let an exchange or vector transfer be split. Rotation is checked from reset, after each owner, and when only a distant agent requests; a pointer that restarted at zero or skipped an agent would grant the wrong line. A randomized phase mixes busy, hold and request patterns, which catches a grant that moves during a transfer or that fails to drop once all requests stop.

// File: rtl/shared_bus_arbiter.sv
module shared_bus_arbiter #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] lock_i,
  input  logic [N-1:0] auto_lock_i,
  input  logic         xfer_busy_i,
  output logic [N-1:0] gnt_o,
  output logic         locked_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr;
  logic [IW-1:0] pick_idx;
  logic [N-1:0]  pick;
  logic          found;

  assign locked_o = |(gnt_o & (lock_i | auto_lock_i));

  always_comb begin
    found    = 1'b0;
    pick_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (!found && req_i[(int'(ptr) + i) % N]) begin
        found    = 1'b1;
        pick_idx = IW'((int'(ptr) + i) % N);
      end
    end
    pick = '0;
    if (found) pick[pick_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_o <= '0;
      ptr   <= '0;
    end else if (!locked_o && !xfer_busy_i) begin
      gnt_o <= pick;
      if (found) ptr <= (int'(pick_idx) == N - 1) ? '0 : pick_idx + 1'b1;
    end
  end
endmodule

module shared_bus_arbiter_sva #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req_i,
  input logic [N-1:0] lock_i,
  input logic [N-1:0] auto_lock_i,
  input logic         xfer_busy_i,
  input logic [N-1:0] gnt_o,
  input logic         locked_o
);
  assert_gnt_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  assert_new_owner_requested_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o != '0 && !$stable(gnt_o)) |-> ((gnt_o & $past(req_i)) != '0));

  assert_busy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy_i |=> $stable(gnt_o));

  assert_lock_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_o & lock_i) != '0) |=> $stable(gnt_o));

  assert_auto_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_o & auto_lock_i) != '0) |=> $stable(gnt_o));

  assert_no_owner_unlocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o == '0) |-> !locked_o);

  assert_idle_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_busy_i && !locked_o && req_i == '0) |=> (gnt_o == '0));
endmodule

bind shared_bus_arbiter shared_bus_arbiter_sva #(.N(N)) u_sva (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .lock_i(lock_i),
  .auto_lock_i(auto_lock_i), .xfer_busy_i(xfer_busy_i),
  .gnt_o(gnt_o), .locked_o(locked_o)
);

// File: tb/shared_bus_arbiter_bench.sv
`timescale 1ns/1ps
module shared_bus_arbiter_bench;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0, lock = '0, alock = '0;
  logic         busy = 1'b0;
  logic [N-1:0] gnt;
  logic         locked;

  int    checks = 0, errors = 0;
  int    owner = -1, rr = 0;
  string tag = "R1";
  bit    done = 1'b0;

  always #10 clk = ~clk;

  shared_bus_arbiter #(.N(N)) u_shared_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req), .lock_i(lock), .auto_lock_i(alock),
    .xfer_busy_i(busy), .gnt_o(gnt), .locked_o(locked)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      owner = -1;
      rr = 0;
    end else if (!(owner >= 0 && (lock[owner] || alock[owner])) && !busy) begin
      int nw;
      nw = -1;
      for (int i = 0; i < N; i++) begin
        if (nw < 0 && req[(rr + i) % N]) nw = (rr + i) % N;
      end
      owner = nw;
      if (nw >= 0) rr = (nw + 1) % N;
    end
  end

  task automatic check(string r, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b at %0t", r, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      logic [N-1:0] eg;
      logic         el;
      eg = (owner < 0) ? '0 : (N'(1) << owner);
      el = (owner >= 0) && (lock[owner] || alock[owner]);
      check(tag, gnt, eg);
      check(tag == "R1" ? "R1" : "R9", {{(N-1){1'b0}}, locked}, {{(N-1){1'b0}}, el});
      check("R2", {{(N-1){1'b0}}, ($countones(gnt) > 1)}, '0);
    end
  end

  task automatic drive(logic [N-1:0] r, logic [N-1:0] l, logic [N-1:0] a,
                       logic b, string t, int cycles);
    @(posedge clk); #2;
    req = r; lock = l; alock = a; busy = b; tag = t;
    repeat (cycles - 1) @(posedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1: first grant after reset goes to agent 0 when all request
    drive(4'b1111, '0, '0, 1'b0, "R1", 1);
    drive(4'b1111, '0, '0, 1'b0, "R4", 6);
    // R5: transfer busy freezes the grant
    drive(4'b1111, '0, '0, 1'b1, "R5", 4);
    drive(4'b1111, '0, '0, 1'b0, "R4", 2);
    // R6/R9: explicit lock on the owner (owner is tracked by the model)
    drive(4'b1111, 4'b1111, '0, 1'b0, "R6", 5);
    drive(4'b1111, '0, '0, 1'b0, "R4", 2);
    // R7: implicit hold for exchange or vector transfer
    drive(4'b1111, '0, 4'b1111, 1'b0, "R7", 5);
    drive(4'b0000, '0, '0, 1'b0, "R10", 3);
    // R8: lock from non-owner agents ignored
    drive(4'b0010, '0, '0, 1'b0, "R3", 2);
    drive(4'b1100, 4'b1101, 4'b1000, 1'b0, "R8", 2);
    drive(4'b0001, 4'b0000, 4'b0010, 1'b0, "R8", 3);
    drive(4'b0000, 4'b0110, 4'b1000, 1'b0, "R8", 3);
    // R3: a single distant requester
    drive(4'b0100, '0, '0, 1'b0, "R3", 3);
    drive(4'b0000, '0, '0, 1'b0, "R10", 2);
    for (int k = 0; k < 400; k++) begin
      drive(N'($urandom), N'($urandom) & N'($urandom), N'($urandom) & N'($urandom) & N'($urandom),
            ($urandom % 4) == 0, "R4", 1);
    end
    drive('0, '0, '0, 1'b0, "R10", 3);
    @(negedge clk); #1;
    finish_run();
  end
endmodule